// File: doc/BRIEF.md
# PTP Event Timestamp Capture

This block sits beside one Ethernet port and watches the byte streams in both directions for precision-time-protocol event messages. On the first data byte after the start-of-frame delimiter of every frame, it copies the running 64-bit clock into a holding register for that direction. The block then parses the header as the bytes stream past. When the message type turns out to be the event that qualifies for that direction, it commits the held time to a capture register set. It also commits the sender's 48-bit UUID and the 16-bit sequence ID, and it raises a one-cycle valid pulse.

A mode input selects master or slave clock behaviour, and this decides which event type qualifies on receive and which on transmit. A second input marks a port that faces the host MAC. For such a port, the stream coming from the switch fabric counts as receive and the stream going toward the fabric counts as transmit. Byte offsets of the type, UUID and sequence fields are parameters. All offsets count from 0, where byte 0 is the first byte after the delimiter.

Top module: `ptp_evt_capture`

## Requirements
- R1: With `master`=0, a receive frame whose type code is 0 (Sync) is captured, and a transmit frame whose type code is 1 (Delay_Req) is captured. The opposite pairing is not captured.
- R2: With `master`=1, a receive frame with type code 1 is captured, and a transmit frame with type code 0 is captured. The opposite pairing is not captured.
- R3: Type codes 2 (Follow_Up), 3 (Delay_Resp) and 4 (Management) never produce a capture pulse and leave all capture outputs unchanged, in either mode or direction.
- R4: A capture holds three values. The timestamp is the value of `clk_time` in the cycle that carries byte 0 with `*_sof`=1. The UUID is bytes UUID_OFS..UUID_OFS+5, and the sequence ID is bytes SEQ_OFS..SEQ_OFS+1, each assembled most significant byte first.
- R5: Every frame start reloads the holding time. A qualifying frame that follows a non-qualifying one reports its own start time.
- R6: With `host_side`=0, the `ing_*` stream is receive and the `egr_*` stream is transmit. With `host_side`=1, the roles are swapped.
- R7: A frame whose `*_eof` byte comes before byte LAST_OFS produces no capture and leaves the capture outputs unchanged. LAST_OFS is the largest of TYPE_OFS, UUID_OFS+5 and SEQ_OFS+1.
- R8: A capture raises `rx_cap_vld` or `tx_cap_vld` for exactly one cycle, in the cycle after byte LAST_OFS is accepted. A later qualifying frame overwrites the capture outputs.
- R9: Receive and transmit have separate holding and capture registers. A capture on one direction leaves the other direction's outputs unchanged.
- R10: The type code is the low 4 bits of byte TYPE_OFS. The high 4 bits do not affect qualification.
- R11: After reset, all capture outputs are zero and no valid pulse is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_side | input | 1 | Port faces the host MAC; swaps receive and transmit |
| master | input | 1 | 1 = master clock mode, 0 = slave |
| clk_time | input | 64 | Running protocol clock time |
| ing_valid | input | 1 | Byte valid, stream entering from the port side |
| ing_sof | input | 1 | First byte after delimiter |
| ing_eof | input | 1 | Last byte of frame |
| ing_data | input | 8 | Frame byte |
| egr_valid | input | 1 | Byte valid, stream leaving toward the port side |
| egr_sof | input | 1 | First byte after delimiter |
| egr_eof | input | 1 | Last byte of frame |
| egr_data | input | 8 | Frame byte |
| rx_ts | output | 64 | Receive capture timestamp |
| rx_uuid | output | 48 | Receive capture source UUID |
| rx_seq | output | 16 | Receive capture sequence ID |
| rx_cap_vld | output | 1 | One-cycle receive capture pulse |
| tx_ts | output | 64 | Transmit capture timestamp |
| tx_uuid | output | 48 | Transmit capture source UUID |
| tx_seq | output | 16 | Transmit capture sequence ID |
| tx_cap_vld | output | 1 | One-cycle transmit capture pulse |

## Verification
The bench walks every pairing of mode, direction, host-side flag and type code. A design with the mode table inverted, or with the host-side swap missing, would pulse on the wrong output, or not pulse at all. The type byte carries a nonzero high nibble, so a design that decoded the whole byte would never capture. A frame that stops one byte short of the last header field is sent, and a design that committed early or did not discard the held time would report a stale capture. Timestamps advance by an odd stride on every frame, so a design that sampled the clock late, or kept the time of an earlier frame, would report the wrong value. Pulse widths are counted, so a valid held for two cycles shows up as well.

// File: rtl/ptp_cap_pkg.sv
package ptp_cap_pkg;

    localparam int TS_W   = 64;
    localparam int UUID_W = 48;
    localparam int SEQ_W  = 16;

    typedef enum logic [3:0] {
        MSG_SYNC       = 4'd0,
        MSG_DELAY_REQ  = 4'd1,
        MSG_FOLLOW_UP  = 4'd2,
        MSG_DELAY_RESP = 4'd3,
        MSG_MGMT       = 4'd4
    } ptp_msg_e;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic [7:0] data;
    } ptp_beat_t;

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [UUID_W-1:0] uuid;
        logic [SEQ_W-1:0]  seq;
    } ptp_cap_t;

    // Receive qualifies Delay_Req in master mode, Sync in slave mode;
    // transmit is the mirror image.
    function automatic logic [3:0] wanted_code(input logic master, input logic is_rx);
        return (master == is_rx) ? MSG_DELAY_REQ : MSG_SYNC;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ptp_stream_sel.sv
module ptp_stream_sel
    import ptp_cap_pkg::*;
(
    input  logic      host_side,
    input  ptp_beat_t ing_beat,
    input  ptp_beat_t egr_beat,
    output ptp_beat_t dir_beat [2]
);
    // index 0 = receive, index 1 = transmit
    always_comb begin
        if (host_side) begin
            dir_beat[0] = egr_beat;
            dir_beat[1] = ing_beat;
        end else begin
            dir_beat[0] = ing_beat;
            dir_beat[1] = egr_beat;
        end
    end
endmodule

// File: rtl/ptp_dir_cap.sv
module ptp_dir_cap
    import ptp_cap_pkg::*;
#(
    parameter bit IS_RX    = 1'b1,
    parameter int TYPE_OFS = 12,
    parameter int UUID_OFS = 4,
    parameter int SEQ_OFS  = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            master,
    input  ptp_beat_t       beat,
    input  logic [TS_W-1:0] clk_time,
    output ptp_cap_t        cap_q,
    output logic            cap_vld
);
    localparam int LAST_OFS = max3(TYPE_OFS, UUID_OFS + 5, SEQ_OFS + 1);
    localparam int CNT_W    = $clog2(LAST_OFS + 2);

    logic              active_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [TS_W-1:0]   hold_q;
    logic [UUID_W-1:0] uuid_q, uuid_n;
    logic [SEQ_W-1:0]  seq_q, seq_n;
    logic [3:0]        type_q, type_n;
    logic [CNT_W-1:0]  idx;
    logic              live;
    logic              commit;
    logic [TS_W-1:0]   ts_now;

    always_comb begin
        idx    = beat.sof ? '0 : cnt_q;
        live   = beat.valid && (beat.sof || active_q);
        uuid_n = uuid_q;
        seq_n  = seq_q;
        type_n = type_q;
        if (live) begin
            if (int'(idx) >= UUID_OFS && int'(idx) < UUID_OFS + 6)
                uuid_n = {uuid_q[UUID_W-9:0], beat.data};
            if (int'(idx) >= SEQ_OFS && int'(idx) < SEQ_OFS + 2)
                seq_n = {seq_q[SEQ_W-9:0], beat.data};
            if (int'(idx) == TYPE_OFS)
                type_n = beat.data[3:0];
        end
        commit = live && (int'(idx) == LAST_OFS) && (type_n == wanted_code(master, IS_RX));
        ts_now = beat.sof ? clk_time : hold_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            hold_q   <= '0;
            uuid_q   <= '0;
            seq_q    <= '0;
            type_q   <= '0;
            cap_q    <= '0;
            cap_vld  <= 1'b0;
        end else begin
            cap_vld <= 1'b0;
            if (live) begin
                uuid_q   <= uuid_n;
                seq_q    <= seq_n;
                type_q   <= type_n;
                cnt_q    <= idx + 1'b1;
                active_q <= !(beat.eof || int'(idx) == LAST_OFS);
                if (beat.sof)
                    hold_q <= clk_time;
            end
            if (commit) begin
                cap_q.ts   <= ts_now;
                cap_q.uuid <= uuid_n;
                cap_q.seq  <= seq_n;
                cap_vld    <= 1'b1;
            end
        end
    end

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        cap_vld |=> !cap_vld); // R8
    AST_CAP_HELD: assert property (@(posedge clk) disable iff (rst)
        !cap_vld |-> $stable(cap_q)); // R3
    AST_TS_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
        cap_vld |-> cap_q.ts == hold_q); // R4
    AST_HOLD_ON_SOF: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && beat.sof) |=> hold_q == $past(clk_time)); // R5

endmodule

// File: rtl/ptp_evt_capture.sv
module ptp_evt_capture
    import ptp_cap_pkg::*;
#(
    parameter int TYPE_OFS = 12,
    parameter int UUID_OFS = 4,
    parameter int SEQ_OFS  = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_side,
    input  logic        master,
    input  logic [63:0] clk_time,
    input  logic        ing_valid,
    input  logic        ing_sof,
    input  logic        ing_eof,
    input  logic [7:0]  ing_data,
    input  logic        egr_valid,
    input  logic        egr_sof,
    input  logic        egr_eof,
    input  logic [7:0]  egr_data,
    output logic [63:0] rx_ts,
    output logic [47:0] rx_uuid,
    output logic [15:0] rx_seq,
    output logic        rx_cap_vld,
    output logic [63:0] tx_ts,
    output logic [47:0] tx_uuid,
    output logic [15:0] tx_seq,
    output logic        tx_cap_vld
);
    ptp_beat_t ing_beat, egr_beat;
    ptp_beat_t dir_beat [2];
    ptp_cap_t  cap      [2];
    logic      vld      [2];

    assign ing_beat = '{valid: ing_valid, sof: ing_sof, eof: ing_eof, data: ing_data};
    assign egr_beat = '{valid: egr_valid, sof: egr_sof, eof: egr_eof, data: egr_data};

    ptp_stream_sel u_sel (
        .host_side (host_side),
        .ing_beat  (ing_beat),
        .egr_beat  (egr_beat),
        .dir_beat  (dir_beat)
    );

    for (genvar g = 0; g < 2; g++) begin : g_dir
        ptp_dir_cap #(
            .IS_RX    (g == 0),
            .TYPE_OFS (TYPE_OFS),
            .UUID_OFS (UUID_OFS),
            .SEQ_OFS  (SEQ_OFS)
        ) u_cap (
            .clk      (clk),
            .rst      (rst),
            .master   (master),
            .beat     (dir_beat[g]),
            .clk_time (clk_time),
            .cap_q    (cap[g]),
            .cap_vld  (vld[g])
        );
    end

    assign rx_ts      = cap[0].ts;
    assign rx_uuid    = cap[0].uuid;
    assign rx_seq     = cap[0].seq;
    assign rx_cap_vld = vld[0];
    assign tx_ts      = cap[1].ts;
    assign tx_uuid    = cap[1].uuid;
    assign tx_seq     = cap[1].seq;
    assign tx_cap_vld = vld[1];

endmodule

// File: tb/ptp_evt_capture_test.sv
module ptp_evt_capture_test;
    localparam int UO = 4, SO = 10, TO = 12, FLEN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_side = 1'b0, master = 1'b0;
    logic [63:0] clk_time = 64'h0000_0100_0000_0000;
    logic        ing_valid = 0, ing_sof = 0, ing_eof = 0;
    logic [7:0]  ing_data = 0;
    logic        egr_valid = 0, egr_sof = 0, egr_eof = 0;
    logic [7:0]  egr_data = 0;
    logic [63:0] rx_ts, tx_ts;
    logic [47:0] rx_uuid, tx_uuid;
    logic [15:0] rx_seq, tx_seq;
    logic        rx_cap_vld, tx_cap_vld;

    int n_chk = 0, n_bad = 0, rx_pulses = 0, tx_pulses = 0, cyc = 0;
    logic [63:0] m_rx_ts = 0, m_tx_ts = 0;
    logic [47:0] m_rx_uuid = 0, m_tx_uuid = 0;
    logic [15:0] m_rx_seq = 0, m_tx_seq = 0;

    ptp_evt_capture uut (.*);

    always #10 clk = ~clk;

    // {host, master, on_egr, code[2:0], exp_rx, exp_tx}
    localparam logic [7:0] VEC [17] = '{
        8'b0_0_0_000_1_0, 8'b0_0_1_001_0_1, 8'b0_0_0_001_0_0, 8'b0_0_1_000_0_0,
        8'b0_1_0_001_1_0, 8'b0_1_1_000_0_1, 8'b0_1_0_000_0_0, 8'b0_1_1_001_0_0,
        8'b0_0_0_010_0_0, 8'b0_0_1_011_0_0, 8'b0_1_0_100_0_0, 8'b0_1_1_010_0_0,
        8'b1_0_1_000_1_0, 8'b1_0_0_001_0_1, 8'b1_1_1_001_1_0, 8'b1_1_0_000_0_1,
        8'b1_0_0_000_0_0
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (rx_cap_vld) rx_pulses++;
        if (tx_cap_vld) tx_pulses++;
        clk_time = clk_time + 64'h0000_0001_0000_0007;
    endtask

    task automatic send(input logic on_egr, input logic [3:0] code, input int len,
                        input logic [47:0] u, input logic [15:0] s, output logic [63:0] ts);
        rx_pulses = 0; tx_pulses = 0; ts = 0;
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            step();
            if (i == 0) ts = clk_time;
            b = 8'(i);
            if (i >= UO && i < UO + 6) b = u[47 - 8*(i-UO) -: 8];
            if (i >= SO && i < SO + 2) b = s[15 - 8*(i-SO) -: 8];
            if (i == TO) b = {4'hA, code}; // R10 high nibble set
            if (on_egr) begin
                egr_valid = 1; egr_sof = (i == 0); egr_eof = (i == len-1); egr_data = b;
            end else begin
                ing_valid = 1; ing_sof = (i == 0); ing_eof = (i == len-1); ing_data = b;
            end
        end
        step();
        ing_valid = 0; ing_sof = 0; ing_eof = 0;
        egr_valid = 0; egr_sof = 0; egr_eof = 0;
        repeat (3) step();
    endtask

    task automatic chk_all(input string rq, input string tq);
        chk(rq, rx_ts, m_rx_ts);
        chk(rq, {16'h0, rx_uuid}, {16'h0, m_rx_uuid});
        chk(rq, {48'h0, rx_seq}, {48'h0, m_rx_seq});
        chk(tq, tx_ts, m_tx_ts);
        chk(tq, {16'h0, tx_uuid}, {16'h0, m_tx_uuid});
        chk(tq, {48'h0, tx_seq}, {48'h0, m_tx_seq});
    endtask

    initial begin
        logic [63:0] ts;
        repeat (3) step();
        rst = 0;
        step();
        // R11 reset state
        chk("R11", {63'h0, rx_cap_vld}, 0);
        chk("R11", {63'h0, tx_cap_vld}, 0);
        chk_all("R11", "R11");

        for (int i = 0; i < 17; i++) begin
            logic [7:0]  v;
            logic [47:0] u;
            logic [15:0] s;
            string rq;
            v = VEC[i];
            host_side = v[7]; master = v[6];
            u = 48'hA1B2_C3D4_0000 + 48'(i * 257);
            s = 16'h1000 + 16'(i * 3);
            send(v[5], {1'b0, v[4:2]}, FLEN, u, s, ts);
            rq = (v[4:2] >= 2) ? "R3" : (v[7] ? "R6" : (v[6] ? "R2" : "R1"));
            chk(rq, 64'(rx_pulses), {63'h0, v[1]}); // R8 exactly one cycle
            chk(rq, 64'(tx_pulses), {63'h0, v[0]});
            if (v[1]) begin m_rx_ts = ts; m_rx_uuid = u; m_rx_seq = s; end
            if (v[0]) begin m_tx_ts = ts; m_tx_uuid = u; m_tx_seq = s; end
            if (v[1]) chk_all("R4", "R9");
            else if (v[0]) chk_all("R9", "R4");
            else chk_all(rq, rq);
        end

        // R7: frame ends right before the last header byte
        host_side = 0; master = 0;
        send(1'b0, 4'd0, TO, 48'h0102_0304_0506, 16'h7777, ts);
        chk("R7", 64'(rx_pulses), 0);
        chk_all("R7", "R7");

        // R5: non-qualifying frame then qualifying frame; R8 overwrite
        send(1'b0, 4'd2, FLEN, 48'h1111_2222_3333, 16'h4444, ts);
        send(1'b0, 4'd0, FLEN, 48'hFEDC_BA98_7654, 16'hBEEF, ts);
        chk("R8", 64'(rx_pulses), 1);
        m_rx_ts = ts; m_rx_uuid = 48'hFEDC_BA98_7654; m_rx_seq = 16'hBEEF;
        chk_all("R5", "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule